// File: doc/BRIEF.md
# Inter-Processor Word Mailbox

This block links two processors through a pair of symmetric register ports, called side A and side B. Each side sees the same four word registers. A sync register carries a 4-bit nibble that this side drives to the other and a 4-bit nibble that the other side drives to this one. Through the same register, either side can kick an interrupt across to the other. A send register pushes 32-bit words into a queue that only the opposite side drains. A receive register pops the words that the opposite side pushed. A control register reports the state of both queues, holds interrupt enables and a queue enable, flushes the outgoing queue and keeps a sticky error flag.

Software on each processor exchanges short messages by writing words into its send register and taking interrupts from the peer. There is one queue per direction, each `DEPTH` words deep (16 by default). Each side has one level interrupt output that combines its enabled queue conditions with a latched sync kick.

Register select (`*_addr_i`): 0 = sync, 1 = control, 2 = send, 3 = receive. Accesses complete in the cycle `*_req_i` is high. Read data is combinational on `*_rdata_o` during that cycle, and the side effects of the access take hold at the following clock edge.

Top module: `ipc_mailbox`

## Requirements
- R1: Sync register bits 11:8 are read/write and hold this side's outgoing nibble. Bits 3:0 are read-only and show the nibble most recently written by the other side. The new value is visible from the cycle after the write.
- R2: A sync write with bit 13 set sets the other side's kick latch, but only if that side has bit 14 of its own sync register (kick enable) set. The other side's `irq_o` is then high from the next cycle. Bit 13 always reads 0.
- R3: Control bits 0 and 1 give send queue empty and full. Bits 8 and 9 give receive queue empty and full. Bits 2, 10 and 15 read back as written. After reset the control register reads 0x0101 and the sync register reads 0.
- R4: With bit 15 set, a send write to a full queue is dropped and sets control bit 14.
- R5: With bit 15 set, a receive read from an empty queue leaves the queue as it is, returns the last word popped (0 after reset) and sets control bit 14.
- R6: Control bit 14 stays set until a control write with bit 14 = 1 clears it. A control write with bit 14 = 0 leaves it set.
- R7: A control write with bit 3 = 1 empties this side's send queue, and the other side's receive queue with it. Bit 3 always reads 0.
- R8: While control bit 15 is 0, send writes and receive reads neither change a queue nor set the error flag.
- R9: Words arrive in the order they were sent. A queue holds exactly `DEPTH` words: full is reported after `DEPTH` pushes.
- R10: `irq_o` is high while any of these holds: bit 2 is set and the send queue is empty; bit 10 is set and the receive queue is not empty; the kick latch is set.
- R11: A read of this side's sync register clears its kick latch.
- R12: A sync write with bit 13 = 0 kicks nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_req_i | input | 1 | Side A register access strobe |
| a_we_i | input | 1 | Side A write (1) or read (0) |
| a_addr_i | input | 2 | Side A register select |
| a_wdata_i | input | 32 | Side A write data |
| a_rdata_o | output | 32 | Side A read data |
| a_irq_o | output | 1 | Side A interrupt |
| b_req_i | input | 1 | Side B register access strobe |
| b_we_i | input | 1 | Side B write (1) or read (0) |
| b_addr_i | input | 2 | Side B register select |
| b_wdata_i | input | 32 | Side B write data |
| b_rdata_o | output | 32 | Side B read data |
| b_irq_o | output | 1 | Side B interrupt |

## Verification
On every cycle, assertions check the following:
- the queues are never pushed when full or popped when empty;
- a flush leaves a queue empty;
- the fill count stays within its depth;
- the error flag is sticky and rises only after a queue access;
- a written nibble appears at the other side on the next cycle;
- an enabled kick latches and a sync read clears it.

Only the bench's scenarios can show the remaining behaviour. That covers word ordering and the exact full point, the return of the last word on an empty read, the effect of a disabled queue and the exact control readback. It also covers which interrupt sources combine on `irq_o`. These are checked against a queue model under directed corner cases and a seeded random mix of sends, receives and status reads on both sides.

// File: rtl/ipc_mailbox_pkg.sv
package ipc_mailbox_pkg;
  localparam int unsigned NIB_W  = 4;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_SYNC = 2'd0,
    REG_CTRL = 2'd1,
    REG_SEND = 2'd2,
    REG_RECV = 2'd3
  } reg_sel_e;

  // sync register fields
  localparam int unsigned SYNC_IN_LSB  = 0;
  localparam int unsigned SYNC_OUT_LSB = 8;
  localparam int unsigned SYNC_KICK    = 13;
  localparam int unsigned SYNC_KICK_EN = 14;

  // control register fields
  localparam int unsigned CTL_TX_EMPTY = 0;
  localparam int unsigned CTL_TX_FULL  = 1;
  localparam int unsigned CTL_TX_IE    = 2;
  localparam int unsigned CTL_FLUSH    = 3;
  localparam int unsigned CTL_RX_EMPTY = 8;
  localparam int unsigned CTL_RX_FULL  = 9;
  localparam int unsigned CTL_RX_IE    = 10;
  localparam int unsigned CTL_ERR      = 14;
  localparam int unsigned CTL_EN       = 15;
endpackage

// File: rtl/ipc_word_fifo.sv
module ipc_word_fifo #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              pop_i,
  input  logic              flush_i,
  output logic [DATA_W-1:0] head_o,
  output logic              empty_o,
  output logic              full_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  count_q;

  assign head_o  = mem_q[rd_ptr_q];
  assign empty_o = (count_q == '0);
  assign full_o  = (count_q == CNT_FULL);

  always_ff @(posedge clk_i) begin
    if (push_i && !flush_i) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_i) wr_ptr_q <= (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + 1'b1;
      if (pop_i)  rd_ptr_q <= (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  a_r4_no_push_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  a_r5_no_pop_when_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  a_r7_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);
  a_r9_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_FULL);
endmodule

// File: rtl/ipc_side_port.sv
module ipc_side_port
  import ipc_mailbox_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  // cross-coupled sync
  input  logic [NIB_W-1:0]  sync_in_i,
  output logic [NIB_W-1:0]  sync_out_o,
  input  logic              kick_i,
  output logic              kick_o,
  // outgoing queue
  output logic              tx_push_o,
  output logic [DATA_W-1:0] tx_wdata_o,
  output logic              tx_flush_o,
  input  logic              tx_empty_i,
  input  logic              tx_full_i,
  // incoming queue
  output logic              rx_pop_o,
  input  logic [DATA_W-1:0] rx_head_i,
  input  logic              rx_empty_i,
  input  logic              rx_full_i
);
  reg_sel_e sel;
  logic wr_sync, rd_sync, wr_ctrl, wr_send, rd_recv;

  logic [NIB_W-1:0]  nib_q;
  logic              kick_en_q, kick_pend_q;
  logic              tx_ie_q, rx_ie_q, err_q, en_q;
  logic [DATA_W-1:0] last_q;
  logic              err_set, err_clr;

  assign sel     = reg_sel_e'(addr_i);
  assign wr_sync = req_i &  we_i & (sel == REG_SYNC);
  assign rd_sync = req_i & !we_i & (sel == REG_SYNC);
  assign wr_ctrl = req_i &  we_i & (sel == REG_CTRL);
  assign wr_send = req_i &  we_i & (sel == REG_SEND);
  assign rd_recv = req_i & !we_i & (sel == REG_RECV);

  assign tx_push_o  = wr_send & en_q & !tx_full_i;
  assign tx_wdata_o = wdata_i;
  assign tx_flush_o = wr_ctrl & wdata_i[CTL_FLUSH];
  assign rx_pop_o   = rd_recv & en_q & !rx_empty_i;
  assign kick_o     = wr_sync & wdata_i[SYNC_KICK];
  assign sync_out_o = nib_q;

  assign err_set = en_q & ((wr_send & tx_full_i) | (rd_recv & rx_empty_i));
  assign err_clr = wr_ctrl & wdata_i[CTL_ERR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nib_q     <= '0;
      kick_en_q <= 1'b0;
      tx_ie_q   <= 1'b0;
      rx_ie_q   <= 1'b0;
      en_q      <= 1'b0;
    end else if (wr_sync) begin
      nib_q     <= wdata_i[SYNC_OUT_LSB +: NIB_W];
      kick_en_q <= wdata_i[SYNC_KICK_EN];
    end else if (wr_ctrl) begin
      tx_ie_q   <= wdata_i[CTL_TX_IE];
      rx_ie_q   <= wdata_i[CTL_RX_IE];
      en_q      <= wdata_i[CTL_EN];
    end
  end

  // set wins over a same-cycle read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    kick_pend_q <= 1'b0;
    else if (kick_i && kick_en_q)   kick_pend_q <= 1'b1;
    else if (rd_sync)               kick_pend_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      err_q <= 1'b0;
    else if (err_set) err_q <= 1'b1;
    else if (err_clr) err_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       last_q <= '0;
    else if (rx_pop_o) last_q <= rx_head_i;
  end

  always_comb begin
    rdata_o = '0;
    case (sel)
      REG_SYNC: begin
        rdata_o[SYNC_IN_LSB +: NIB_W]  = sync_in_i;
        rdata_o[SYNC_OUT_LSB +: NIB_W] = nib_q;
        rdata_o[SYNC_KICK_EN]          = kick_en_q;
      end
      REG_CTRL: begin
        rdata_o[CTL_TX_EMPTY] = tx_empty_i;
        rdata_o[CTL_TX_FULL]  = tx_full_i;
        rdata_o[CTL_TX_IE]    = tx_ie_q;
        rdata_o[CTL_RX_EMPTY] = rx_empty_i;
        rdata_o[CTL_RX_FULL]  = rx_full_i;
        rdata_o[CTL_RX_IE]    = rx_ie_q;
        rdata_o[CTL_ERR]      = err_q;
        rdata_o[CTL_EN]       = en_q;
      end
      REG_RECV: rdata_o = rx_pop_o ? rx_head_i : last_q;
      default:  rdata_o = '0;
    endcase
  end

  assign irq_o = (tx_ie_q & tx_empty_i) | (rx_ie_q & !rx_empty_i) | kick_pend_q;

  a_r1_nibble_follows_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_sync |=> (sync_out_o == $past(wdata_i[SYNC_OUT_LSB +: NIB_W])));
  a_r2_kick_latched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kick_i && kick_en_q) |=> irq_o);
  a_r11_read_clears_kick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_sync && !kick_i) |=> !kick_pend_q);
  a_r6_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !wr_ctrl) |=> err_q);
  a_r6_err_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_q) |-> $past(en_q && (wr_send || rd_recv)));
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import ipc_mailbox_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              a_req_i,
  input  logic              a_we_i,
  input  logic [1:0]        a_addr_i,
  input  logic [DATA_W-1:0] a_wdata_i,
  output logic [DATA_W-1:0] a_rdata_o,
  output logic              a_irq_o,
  input  logic              b_req_i,
  input  logic              b_we_i,
  input  logic [1:0]        b_addr_i,
  input  logic [DATA_W-1:0] b_wdata_i,
  output logic [DATA_W-1:0] b_rdata_o,
  output logic              b_irq_o
);
  logic [NIB_W-1:0]  a_nib, b_nib;
  logic              a_kick, b_kick;
  logic              ab_push, ab_pop, ab_flush, ab_empty, ab_full;
  logic              ba_push, ba_pop, ba_flush, ba_empty, ba_full;
  logic [DATA_W-1:0] ab_wdata, ab_head, ba_wdata, ba_head;

  ipc_word_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo_ab (
    .clk_i, .rst_ni,
    .push_i (ab_push), .wdata_i(ab_wdata), .pop_i(ab_pop), .flush_i(ab_flush),
    .head_o (ab_head), .empty_o(ab_empty), .full_o(ab_full)
  );

  ipc_word_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo_ba (
    .clk_i, .rst_ni,
    .push_i (ba_push), .wdata_i(ba_wdata), .pop_i(ba_pop), .flush_i(ba_flush),
    .head_o (ba_head), .empty_o(ba_empty), .full_o(ba_full)
  );

  ipc_side_port #(.DATA_W(DATA_W)) u_side_a (
    .clk_i, .rst_ni,
    .req_i(a_req_i), .we_i(a_we_i), .addr_i(a_addr_i), .wdata_i(a_wdata_i),
    .rdata_o(a_rdata_o), .irq_o(a_irq_o),
    .sync_in_i(b_nib), .sync_out_o(a_nib), .kick_i(b_kick), .kick_o(a_kick),
    .tx_push_o(ab_push), .tx_wdata_o(ab_wdata), .tx_flush_o(ab_flush),
    .tx_empty_i(ab_empty), .tx_full_i(ab_full),
    .rx_pop_o(ba_pop), .rx_head_i(ba_head), .rx_empty_i(ba_empty), .rx_full_i(ba_full)
  );

  ipc_side_port #(.DATA_W(DATA_W)) u_side_b (
    .clk_i, .rst_ni,
    .req_i(b_req_i), .we_i(b_we_i), .addr_i(b_addr_i), .wdata_i(b_wdata_i),
    .rdata_o(b_rdata_o), .irq_o(b_irq_o),
    .sync_in_i(a_nib), .sync_out_o(b_nib), .kick_i(a_kick), .kick_o(b_kick),
    .tx_push_o(ba_push), .tx_wdata_o(ba_wdata), .tx_flush_o(ba_flush),
    .tx_empty_i(ba_empty), .tx_full_i(ba_full),
    .rx_pop_o(ab_pop), .rx_head_i(ab_head), .rx_empty_i(ab_empty), .rx_full_i(ab_full)
  );
endmodule

// File: tb/ipc_mailbox_test.sv
module ipc_mailbox_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req   [2];
  logic        we    [2];
  logic [1:0]  addr  [2];
  logic [31:0] wdata [2];
  logic [31:0] rdata [2];
  logic        irq   [2];

  int errors = 0;
  int checks = 0;

  // bench model
  logic [31:0] q_ab [$];
  logic [31:0] q_ba [$];
  logic        m_en [2];
  logic        m_err [2];
  logic        m_tie [2];
  logic        m_rie [2];
  logic [31:0] m_last [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  ipc_mailbox uut (
    .clk_i(clk), .rst_ni(rst_n),
    .a_req_i(req[0]), .a_we_i(we[0]), .a_addr_i(addr[0]), .a_wdata_i(wdata[0]),
    .a_rdata_o(rdata[0]), .a_irq_o(irq[0]),
    .b_req_i(req[1]), .b_we_i(we[1]), .b_addr_i(addr[1]), .b_wdata_i(wdata[1]),
    .b_rdata_o(rdata[1]), .b_irq_o(irq[1])
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic access(int s, logic w, logic [1:0] a, logic [31:0] d, output logic [31:0] q);
    @(negedge clk);
    req[s] = 1'b1; we[s] = w; addr[s] = a; wdata[s] = d;
    #1 q = rdata[s];
    @(posedge clk);
    #1 req[s] = 1'b0; we[s] = 1'b0;
  endtask

  function automatic int tx_n(int s);
    return (s == 0) ? q_ab.size() : q_ba.size();
  endfunction
  function automatic int rx_n(int s);
    return (s == 0) ? q_ba.size() : q_ab.size();
  endfunction

  function automatic logic [31:0] exp_ctrl(int s);
    logic [31:0] v = '0;
    v[0]  = (tx_n(s) == 0);
    v[1]  = (tx_n(s) == DEPTH);
    v[2]  = m_tie[s];
    v[8]  = (rx_n(s) == 0);
    v[9]  = (rx_n(s) == DEPTH);
    v[10] = m_rie[s];
    v[14] = m_err[s];
    v[15] = m_en[s];
    return v;
  endfunction

  function automatic logic exp_irq(int s);
    return (m_tie[s] && tx_n(s) == 0) || (m_rie[s] && rx_n(s) != 0);
  endfunction

  task automatic wr_ctrl(int s, logic [31:0] d);
    logic [31:0] q;
    m_tie[s] = d[2]; m_rie[s] = d[10]; m_en[s] = d[15];
    if (d[14]) m_err[s] = 1'b0;
    if (d[3]) begin
      if (s == 0) q_ab.delete(); else q_ba.delete();
    end
    access(s, 1'b1, 2'd1, d, q);
  endtask

  task automatic chk_ctrl(int s, string tag);
    logic [31:0] q;
    access(s, 1'b0, 2'd1, '0, q);
    check(tag, q, exp_ctrl(s));
  endtask

  task automatic do_send(int s, logic [31:0] d);
    logic [31:0] q;
    if (m_en[s]) begin
      if (tx_n(s) == DEPTH) m_err[s] = 1'b1;
      else if (s == 0) q_ab.push_back(d);
      else q_ba.push_back(d);
    end
    access(s, 1'b1, 2'd2, d, q);
  endtask

  task automatic do_recv(int s, string tag);
    logic [31:0] q, e;
    if (m_en[s]) begin
      if (rx_n(s) == 0) m_err[s] = 1'b1;
      else if (s == 0) m_last[s] = q_ba.pop_front();
      else m_last[s] = q_ab.pop_front();
    end
    e = m_last[s];
    access(s, 1'b0, 2'd3, '0, q);
    check(tag, q, e);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] q;
    void'($urandom(32'h5eed_1234));
    for (int s = 0; s < 2; s++) begin
      req[s] = 0; we[s] = 0; addr[s] = 0; wdata[s] = 0;
      m_en[s] = 0; m_err[s] = 0; m_tie[s] = 0; m_rie[s] = 0; m_last[s] = 0;
    end
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R3 reset state
    for (int s = 0; s < 2; s++) begin
      access(s, 1'b0, 2'd1, '0, q);
      check("R3 reset ctrl", q, 32'h0000_0101);
      access(s, 1'b0, 2'd0, '0, q);
      check("R3 reset sync", q, 32'h0);
      check("R10 reset irq", {31'b0, irq[s]}, 32'h0);
    end

    // R8 disabled queues
    do_send(0, 32'hdead_beef);
    chk_ctrl(1, "R8 disabled send ignored");
    do_recv(1, "R8 disabled recv returns last");
    chk_ctrl(1, "R8 disabled no error");

    wr_ctrl(0, 32'h8000);
    wr_ctrl(1, 32'h8000);

    // R1 nibble crossing
    access(0, 1'b1, 2'd0, 32'h0000_0500, q);
    access(1, 1'b0, 2'd0, '0, q);
    check("R1 remote nibble", q, 32'h0000_0005);
    access(0, 1'b0, 2'd0, '0, q);
    check("R1 own nibble", q, 32'h0000_0500);

    // R2 / R11 / R12 kick
    access(1, 1'b1, 2'd0, 32'h0000_4000, q);
    access(0, 1'b1, 2'd0, 32'h0000_2500, q);
    check("R2 kick raises remote irq", {31'b0, irq[1]}, 32'h1);
    access(0, 1'b0, 2'd0, '0, q);
    check("R2 kick bit reads 0", q, 32'h0000_0500);
    access(1, 1'b0, 2'd0, '0, q);
    check("R2 remote sync readback", q, 32'h0000_4005);
    check("R11 sync read clears kick", {31'b0, irq[1]}, 32'h0);
    access(0, 1'b1, 2'd0, 32'h0000_0500, q);
    check("R12 no kick on zero", {31'b0, irq[1]}, 32'h0);
    access(1, 1'b1, 2'd0, 32'h0000_6000, q);
    check("R2 kick ignored when disabled", {31'b0, irq[0]}, 32'h0);
    access(0, 1'b0, 2'd0, '0, q);
    check("R2 disabled kick sync", q, 32'h0000_0500);

    // R9 fill, R4 overflow
    for (int i = 0; i < DEPTH; i++) do_send(0, $urandom);
    chk_ctrl(0, "R9 send full after DEPTH");
    chk_ctrl(1, "R9 recv full after DEPTH");
    do_send(0, 32'h1111_2222);
    chk_ctrl(0, "R4 overflow sets error");
    for (int i = 0; i < DEPTH; i++) do_recv(1, "R9 order");
    // R5 underflow
    do_recv(1, "R5 empty read returns last");
    chk_ctrl(1, "R5 underflow sets error");
    // R6 sticky error
    wr_ctrl(1, 32'h8000);
    chk_ctrl(1, "R6 error stays on write 0");
    wr_ctrl(1, 32'hc000);
    chk_ctrl(1, "R6 error cleared by write 1");
    wr_ctrl(0, 32'hc000);

    // R10 irq sources, R7 flush
    wr_ctrl(0, 32'h8004);
    check("R10 send empty irq", {31'b0, irq[0]}, {31'b0, exp_irq(0)});
    do_send(0, 32'h0bad_f00d);
    check("R10 send nonempty irq low", {31'b0, irq[0]}, {31'b0, exp_irq(0)});
    do_send(0, 32'h0000_0042);
    wr_ctrl(1, 32'h8400);
    check("R10 recv not empty irq", {31'b0, irq[1]}, 32'h1);
    wr_ctrl(0, 32'h800c);
    chk_ctrl(0, "R7 flush empties send");
    chk_ctrl(1, "R7 flush empties remote recv");
    check("R7 flush drops recv irq", {31'b0, irq[1]}, 32'h0);
    check("R10 irq after flush", {31'b0, irq[0]}, 32'h1);
    do_recv(1, "R7 read after flush");
    wr_ctrl(0, 32'hc000);
    wr_ctrl(1, 32'hc000);

    // random mix
    for (int i = 0; i < 600; i++) begin
      int op = int'($urandom_range(0, 5));
      int s  = int'($urandom_range(0, 1));
      case (op)
        0, 1: do_send(s, $urandom);
        2, 3: do_recv(s, "R9 random recv");
        4:    chk_ctrl(s, "R3 random ctrl");
        default: begin
          wr_ctrl(s, ($urandom_range(0, 1) != 0) ? 32'hc000 : 32'h8000);
          check("R10 random irq", {31'b0, irq[s]}, 32'h0);
        end
      endcase
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule